// File: doc/BRIEF.md
# Secondary-Device Presence and Diagnostics Signaller

This block sits in the second of two devices that share one host bus. It drives two active-low open-drain lines that the first device watches. The presence line first tells the partner that a second device is fitted. It does this for a bounded window after reset. Once that window is over, the line only shows that the device is busy with work. The diagnostics line tells the partner whether this device is still busy after a reset or a self-test command, or whether it has finished and can report status.

Each line is controlled through one drive-low enable. A 1 pulls the wire low, which asserts the active-low signal. A 0 releases the wire to its external pull-up. All time bounds are counted in pulses of a millisecond tick input, and each bound is a parameter. A test bench can therefore use short windows. The hardware reset is synchronous and active high. The software reset, the command-accepted strobe and the self-test command strobe are single-cycle pulses. The device's own firmware raises a busy flag while its reset or self-test work is in progress.

Top module: `sec_dev_signaller`

## Requirements
- R1: While `rst` is high at a clock edge, both `presDrvLow` and `diagDrvLow` are 0 after that edge, whatever the other inputs are (1 = pull line low, 0 = release).
- R2: At the first clock edge after `rst` falls, `presDrvLow` becomes 1 and stays 1 for the announcement window.
- R3: The announcement ends, and `presDrvLow` returns to 0, at the edge that samples `cmdAccepted` high, or at the edge that samples the `PRES_HOLD_MS`-th `msTick` counted after the announcement began, whichever comes first.
- R4: Once the announcement has ended, `presDrvLow` follows `actReq` with one cycle of delay. During the announcement, `actReq` has no effect and `presDrvLow` stays 1.
- R5: After a hardware reset, `diagDrvLow` stays 0 (busy) until an edge samples `busy` low, and at that edge it becomes 1 (passed). It then stays 1 regardless of `busy` until a new reset or command.
- R6: A `swRst` pulse makes `diagDrvLow` 0 at the next edge and starts a reset-length busy phase. The presence line and its announcement timer are not affected.
- R7: If `busy` stays high through a reset busy phase, `diagDrvLow` becomes 1 at the edge that samples the `DIAG_RST_MS`-th tick of that phase.
- R8: A `diagCmd` pulse makes `diagDrvLow` 0 at the next edge. It becomes 1 at the first later edge that samples `busy` low, or at the edge that samples the `DIAG_CMD_MS`-th tick, so it is released for at least one cycle.
- R9: When `swRst` and `diagCmd` arrive in the same cycle, `swRst` wins, and the busy phase uses the `DIAG_RST_MS` bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset (also used as power-on) |
| msTick | input | 1 | One-cycle pulse each millisecond |
| swRst | input | 1 | Software reset pulse |
| cmdAccepted | input | 1 | Pulse: first valid command accepted |
| diagCmd | input | 1 | Pulse: self-test command received |
| busy | input | 1 | High while reset or self-test work is in progress |
| actReq | input | 1 | Device activity request for the presence line |
| presDrvLow | output | 1 | 1 pulls the presence/activity line low |
| diagDrvLow | output | 1 | 1 pulls the diagnostics-passed line low |

## Verification
Every result in this block appears after exactly one clock edge. A strobe, a `busy` level, an `actReq` level, or the final tick of a window is sampled at an edge, and the output has its new value right after that same edge. There is no added pipeline delay. The driver applies one input vector at each falling edge and queues the output it expects after the next rising edge. The monitor compares that expectation one time step after the rising edge. Expected values are therefore always tied to the single edge that should produce them. Timeout cases are checked on the tick just before the bound and on the tick that reaches it.

// File: rtl/sec_sig_pkg.sv
package sec_sig_pkg;

  typedef enum logic [1:0] {
    PS_OFF      = 2'd0,
    PS_ANNOUNCE = 2'd1,
    PS_RELEASED = 2'd2
  } presState_t;

  typedef enum logic [1:0] {
    DS_RST_BUSY = 2'd0,
    DS_CMD_BUSY = 2'd1,
    DS_PASSED   = 2'd2
  } diagState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic presRun;
    logic presClr;
    logic diagRun;
    logic diagClr;
    logic diagLongSel;
  } strobes_t;

endpackage

// File: rtl/sec_sig_tick_timer.sv
module sec_sig_tick_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         expired
);

  logic [W-1:0] cnt;

  assign expired = run && tick && (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (run && tick) begin
      cnt <= expired ? '0 : cnt + 1'b1;
    end
  end

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < limit)) else $error("count passed limit"); // R7

endmodule

// File: rtl/sec_sig_datapath.sv
module sec_sig_datapath
  import sec_sig_pkg::*;
#(
  parameter int unsigned CW           = 16,
  parameter int unsigned PRES_HOLD_MS = 31000,
  parameter int unsigned DIAG_RST_MS  = 30000,
  parameter int unsigned DIAG_CMD_MS  = 5000
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     msTick,
  input  logic     actReq,
  input  strobes_t strb,
  output logic     presExpired,
  output logic     diagExpired,
  output logic     actLatched
);

  localparam logic [CW-1:0] PRES_LIM  = CW'(PRES_HOLD_MS);
  localparam logic [CW-1:0] DRST_LIM  = CW'(DIAG_RST_MS);
  localparam logic [CW-1:0] DCMD_LIM  = CW'(DIAG_CMD_MS);

  logic [CW-1:0] diagLimit;
  assign diagLimit = strb.diagLongSel ? DRST_LIM : DCMD_LIM;

  sec_sig_tick_timer #(.W(CW)) presTimer_i (
    .clk     (clk),
    .rst     (rst),
    .clr     (strb.presClr),
    .run     (strb.presRun),
    .tick    (msTick),
    .limit   (PRES_LIM),
    .expired (presExpired)
  );

  sec_sig_tick_timer #(.W(CW)) diagTimer_i (
    .clk     (clk),
    .rst     (rst),
    .clr     (strb.diagClr),
    .run     (strb.diagRun),
    .tick    (msTick),
    .limit   (diagLimit),
    .expired (diagExpired)
  );

  always_ff @(posedge clk) begin
    if (rst) actLatched <= 1'b0;
    else     actLatched <= actReq;
  end

  AST_NO_RUN_AND_CLR: assert property (@(posedge clk) disable iff (rst)
    !(strb.diagRun && strb.diagClr)) else $error("diag timer run with clear"); // R8

endmodule

// File: rtl/sec_sig_control.sv
module sec_sig_control
  import sec_sig_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     swRst,
  input  logic     cmdAccepted,
  input  logic     diagCmd,
  input  logic     busy,
  input  logic     presExpired,
  input  logic     diagExpired,
  input  logic     actLatched,
  output strobes_t strb,
  output logic     presDrvLow,
  output logic     diagDrvLow
);

  presState_t presSt, presNext;
  diagState_t diagSt, diagNext;
  logic       diagBusyPhase;
  logic       diagRestart;

  assign diagBusyPhase = (diagSt != DS_PASSED);
  assign diagRestart   = swRst || diagCmd;

  assign strb = '{
    presRun:     (presSt == PS_ANNOUNCE),
    presClr:     (presSt != PS_ANNOUNCE),
    diagRun:     diagBusyPhase && !diagRestart,
    diagClr:     diagRestart,
    diagLongSel: (diagSt == DS_RST_BUSY)
  };

  always_comb begin
    presNext = presSt;
    unique case (presSt)
      PS_OFF:      presNext = PS_ANNOUNCE;
      PS_ANNOUNCE: if (cmdAccepted || presExpired) presNext = PS_RELEASED;
      default:     presNext = PS_RELEASED;
    endcase
  end

  always_comb begin
    diagNext = diagSt;
    if (swRst)                                              diagNext = DS_RST_BUSY;
    else if (diagCmd)                                       diagNext = DS_CMD_BUSY;
    else if (diagBusyPhase && (!busy || diagExpired))       diagNext = DS_PASSED;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      presSt <= PS_OFF;
      diagSt <= DS_RST_BUSY;
    end else begin
      presSt <= presNext;
      diagSt <= diagNext;
    end
  end

  assign presDrvLow = (presSt == PS_ANNOUNCE) || ((presSt == PS_RELEASED) && actLatched);
  assign diagDrvLow = (diagSt == DS_PASSED);

  AST_RST_RELEASES_LINES: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!presDrvLow && !diagDrvLow)) else $error("line driven after reset"); // R1
  AST_ANNOUNCE_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |=> presDrvLow) else $error("no presence announcement"); // R2
  AST_SWRST_BUSY: assert property (@(posedge clk) disable iff (rst)
    swRst |=> !diagDrvLow) else $error("swRst did not release diag"); // R6
  AST_CMD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (diagCmd && !swRst) |=> !diagDrvLow) else $error("diagCmd did not release diag"); // R8
  AST_PASSED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (diagDrvLow && !swRst && !diagCmd) |=> diagDrvLow) else $error("passed dropped"); // R5

endmodule

// File: rtl/sec_dev_signaller.sv
module sec_dev_signaller
  import sec_sig_pkg::*;
#(
  parameter int unsigned PRES_HOLD_MS = 31000,
  parameter int unsigned DIAG_RST_MS  = 30000,
  parameter int unsigned DIAG_CMD_MS  = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic msTick,
  input  logic swRst,
  input  logic cmdAccepted,
  input  logic diagCmd,
  input  logic busy,
  input  logic actReq,
  output logic presDrvLow,
  output logic diagDrvLow
);

  localparam int unsigned MAX_A = (PRES_HOLD_MS > DIAG_RST_MS) ? PRES_HOLD_MS : DIAG_RST_MS;
  localparam int unsigned MAX_MS = (MAX_A > DIAG_CMD_MS) ? MAX_A : DIAG_CMD_MS;
  localparam int unsigned CW = $clog2(MAX_MS + 1);

  strobes_t strb;
  logic     presExpired;
  logic     diagExpired;
  logic     actLatched;

  sec_sig_control ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .swRst       (swRst),
    .cmdAccepted (cmdAccepted),
    .diagCmd     (diagCmd),
    .busy        (busy),
    .presExpired (presExpired),
    .diagExpired (diagExpired),
    .actLatched  (actLatched),
    .strb        (strb),
    .presDrvLow  (presDrvLow),
    .diagDrvLow  (diagDrvLow)
  );

  sec_sig_datapath #(
    .CW           (CW),
    .PRES_HOLD_MS (PRES_HOLD_MS),
    .DIAG_RST_MS  (DIAG_RST_MS),
    .DIAG_CMD_MS  (DIAG_CMD_MS)
  ) dp_i (
    .clk         (clk),
    .rst         (rst),
    .msTick      (msTick),
    .actReq      (actReq),
    .strb        (strb),
    .presExpired (presExpired),
    .diagExpired (diagExpired),
    .actLatched  (actLatched)
  );

endmodule

// File: tb/sec_dev_signaller_tb_top.sv
`timescale 1ns/1ps
module sec_dev_signaller_tb_top;

  localparam int unsigned HOLD = 20;
  localparam int unsigned DRST = 30;
  localparam int unsigned DCMD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1, msTick = 1'b0, swRst = 1'b0, cmdAccepted = 1'b0;
  logic diagCmd = 1'b0, busy = 1'b1, actReq = 1'b0;
  logic presDrvLow, diagDrvLow;

  always #2.5 clk = ~clk;

  sec_dev_signaller #(.PRES_HOLD_MS(HOLD), .DIAG_RST_MS(DRST), .DIAG_CMD_MS(DCMD)) dut_i (
    .clk(clk), .rst(rst), .msTick(msTick), .swRst(swRst), .cmdAccepted(cmdAccepted),
    .diagCmd(diagCmd), .busy(busy), .actReq(actReq),
    .presDrvLow(presDrvLow), .diagDrvLow(diagDrvLow)
  );

  typedef struct {
    logic  eP;
    logic  eD;
    bit    chk;
    string tag;
  } exp_t;

  exp_t expQ[$];
  int   vectors = 0;
  int   miscompares = 0;
  bit   done = 1'b0;

  // driver: one input vector per cycle, expected outputs after the next rising edge
  task automatic step(input logic r, s, c, d, b, a, t,
                      input logic eP, eD, input bit chk, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; swRst = s; cmdAccepted = c; diagCmd = d; busy = b; actReq = a; msTick = t;
    e.eP = eP; e.eD = eD; e.chk = chk; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic ticks(input int n, input logic b, a, eP, eD, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, b, a, 1, eP, eD, 1, tag);
  endtask

  // monitor: compares just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        if (e.chk) begin
          vectors++;
          if (presDrvLow !== e.eP || diagDrvLow !== e.eD) begin
            miscompares++;
            $display("FAIL %s: actual pres=%b diag=%b expected pres=%b diag=%b",
                     e.tag, presDrvLow, diagDrvLow, e.eP, e.eD);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R1 reset state; other strobes ignored while in reset
    for (int i = 0; i < 3; i++) step(1, 1, 1, 1, 1, 1, 1, 0, 0, 1, "R1 reset holds lines released");
    // R2 announcement, R5 busy after reset
    step(0, 0, 0, 0, 1, 0, 0, 1, 0, 1, "R2 presence asserted after reset");
    ticks(HOLD - 1, 1, 0, 1, 0, "R3 announcement held before bound");
    step(0, 0, 0, 0, 1, 0, 1, 0, 0, 1, "R3 announcement ends at timeout");
    step(0, 0, 0, 0, 1, 1, 0, 1, 0, 1, "R4 activity drives presence");
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 1, "R4 activity released");
    ticks(DRST - HOLD - 1, 1, 0, 0, 0, "R7 diag busy before reset bound");
    step(0, 0, 0, 0, 1, 0, 1, 0, 1, 1, "R7 diag passed at reset timeout");
    step(0, 0, 0, 0, 1, 0, 0, 0, 1, 1, "R5 passed holds with busy high");

    // R1 reset mid-operation, then command ends announcement
    step(1, 0, 0, 0, 1, 1, 0, 0, 0, 1, "R1 reset overrides passed state");
    step(0, 0, 0, 0, 1, 1, 0, 1, 0, 1, "R2 presence asserted again");
    step(0, 0, 0, 0, 1, 0, 0, 1, 0, 1, "R4 actReq low ignored during announcement");
    ticks(2, 1, 0, 1, 0, "R3 announcement held");
    step(0, 0, 1, 0, 1, 0, 0, 0, 0, 1, "R3 announcement ends on command accepted");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R5 diag passed when busy clears");

    // R6 software reset
    step(0, 1, 0, 0, 1, 0, 0, 0, 0, 1, "R6 swRst releases diag, presence unchanged");
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 1, "R6 busy phase");
    ticks(DCMD + 2, 1, 0, 0, 0, "R6 reset bound longer than command bound");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R6 passed after busy clears");

    // R8 self-test command with timeout
    step(0, 0, 0, 1, 1, 0, 0, 0, 0, 1, "R8 diagCmd releases diag");
    ticks(DCMD - 1, 1, 0, 0, 0, "R8 busy before command bound");
    step(0, 0, 0, 0, 1, 0, 1, 0, 1, 1, "R8 passed at command timeout");
    // R8 command with busy already low: one released cycle
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, 1, "R8 diagCmd with busy low still releases");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R8 passed one cycle later");

    // R9 priority of software reset over command
    step(0, 1, 0, 1, 1, 0, 0, 0, 0, 1, "R9 swRst and diagCmd together");
    ticks(DCMD, 1, 0, 0, 0, "R9 command bound not applied");
    ticks(DRST - DCMD - 1, 1, 0, 0, 0, "R9 still busy");
    step(0, 0, 0, 0, 1, 0, 1, 0, 1, 1, "R9 passed at reset bound");

    // R6 software reset during announcement does not disturb presence
    step(1, 0, 0, 0, 1, 0, 0, 0, 0, 1, "R1 reset");
    step(0, 0, 0, 0, 1, 0, 0, 1, 0, 1, "R2 presence asserted");
    ticks(5, 1, 0, 1, 0, "R3 announcement held");
    step(0, 1, 0, 0, 1, 0, 0, 1, 0, 1, "R6 swRst keeps announcement");
    ticks(HOLD - 6, 1, 0, 1, 0, "R6 announcement timer not restarted");
    step(0, 0, 0, 0, 1, 0, 1, 0, 0, 1, "R6 announcement ends on original bound");

    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "drain");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule